// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller Sequencer

This block sits between a simple word-addressed register bus and a one-time-programmable fuse array. It keeps a bank of shadow registers that mirror the fuse words. Software reads the shadows directly and never waits on the fuse macro. Three commands drive the fuse macro: read one word into its shadow, program one word, and reload every shadow from the fuses without a module reset. The read and program strobes are shaped by cycle counts from a timing register. Each strobe is framed by a setup interval and by one relax interval on each side of the active window.

Status and control bits show when an operation is in flight and when an illegal access was tried. Per-word lock bits block programming, and a lock bit can only be set. A fuse bit can only move from 0 to 1. After a successful program, the shadow is updated by OR-ing in the programmed data, which matches what the fuse array now holds.

Top module: `otp_fuse_seq`

## Requirements
- R1: After reset the status word at word address 0 reads 0 (bit 0 = busy, bit 1 = error), every shadow word reads 0, and no strobe is active.
- R2: A read command is a write of op code 1 in bits [1:0] and the word index in bits [8+:IW] to address 1. It holds the read strobe low for SETUP+1 cycles and then RELAX+1 cycles. It then raises the strobe, and the word returned by the array appears in that word's shadow, which is read at address 32+index. The timing register at address 3 holds SETUP in [7:0], RELAX in [15:8], read count in [23:16] and program count in [31:24].
- R3: The active strobe window lasts (count+1) - 2*(RELAX+1) cycles. If that value is below 1, the window lasts 1 cycle. The window is followed by RELAX+1 idle cycles before the operation ends.
- R4: A program command (op code 2) holds the program strobe low for 2*(RELAX+1) cycles and then raises it for the program window. While the strobe is high, the fuse data bus carries the word written to address 2. The word's shadow becomes its old value OR the programmed data.
- R5: Busy is set from the cycle after an accepted command until the operation ends. Read and program strobes are active only while busy is set.
- R6: A command with a nonzero op code that arrives while busy or error is set does three things: it sets error, it starts no strobe, and it leaves every shadow unchanged.
- R7: Writing to the lock register (address 4) sets the lock bits given as ones. Writing zeros clears no lock bit. A program command to a locked word sets error and raises no program strobe.
- R8: Writing a 1 to bit 1 of the clear alias at address 5 clears error. Writing 0 there leaves error set.
- R9: A reload command (op code 3) reads every word in index order 0 to NW-1. Each word gets the full read sequence, busy stays set across the whole sweep, and every shadow then equals its fuse word.
- R10: Address 6 always reads the fixed VERSION parameter value (default 0x00010003), and writes to it have no effect.
- R11: The timing fields and program data are captured when a command is accepted. A later write to the timing register does not change the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | AW (6) | Word address; MSB set selects the shadow region |
| bus_wdata | input | DW (32) | Register write data |
| bus_rdata | output | DW (32) | Combinational read data for bus_addr |
| fuse_addr | output | IW (3) | Fuse word index under operation |
| fuse_rd_stb | output | 1 | Fuse read strobe |
| fuse_pg_stb | output | 1 | Fuse program strobe |
| fuse_wdata | output | DW (32) | Data to program, zero outside program operations |
| fuse_rdata | input | DW (32) | Fuse word returned by the array |

## Verification
A wrong phase counter in the sequencer shows at the strobe pins on the first operation. The strobe rises at the wrong cycle, or stays high for the wrong number of cycles, and busy drops early or late. The bench measures all three against the timing fields.

A wrong capture or merge in the shadow bank shows up at the next shadow read after the operation ends. A reload that skips or reorders words shows in the order of indices at the rising edges of the read strobe.

Faulty error or lock handling shows in two ways. A rejected command may still raise a strobe within a few cycles, or the error bit may read back wrong right after the offending write.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int OTP_TW = 8;           // width of each timing field
    localparam int OTP_CW = OTP_TW + 1;  // width of derived cycle counts

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_READ   = 2'd1,
        OP_PROG   = 2'd2,
        OP_RELOAD = 2'd3
    } otp_op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PRE,
        PH_ACT,
        PH_POST
    } otp_phase_e;

    typedef struct packed {
        logic [OTP_TW-1:0] strobe_prog;
        logic [OTP_TW-1:0] strobe_read;
        logic [OTP_TW-1:0] relax;
        logic [OTP_TW-1:0] setup_rd;
    } otp_timing_t;

    typedef struct packed {
        logic [OTP_CW-1:0] setup;
        logic [OTP_CW-1:0] relax;
        logic [OTP_CW-1:0] pulse;
    } otp_lens_t;

    localparam logic [2:0] REG_CTRL    = 3'd0;
    localparam logic [2:0] REG_CMD     = 3'd1;
    localparam logic [2:0] REG_PDATA   = 3'd2;
    localparam logic [2:0] REG_TIMING  = 3'd3;
    localparam logic [2:0] REG_LOCK    = 3'd4;
    localparam logic [2:0] REG_ERRCLR  = 3'd5;
    localparam logic [2:0] REG_VERSION = 3'd6;

    // Turn raw timing fields into phase lengths in cycles.
    function automatic otp_lens_t make_lens(otp_timing_t t, logic prog);
        otp_lens_t l;
        int        s;
        int        strobe;
        strobe  = prog ? int'(t.strobe_prog) : int'(t.strobe_read);
        s       = strobe + 1 - 2 * (int'(t.relax) + 1);
        if (s < 1) s = 1;
        l.relax = {1'b0, t.relax} + OTP_CW'(1);
        l.setup = prog ? l.relax : ({1'b0, t.setup_rd} + OTP_CW'(1));
        l.pulse = OTP_CW'(s);
        return l;
    endfunction

endpackage

// File: rtl/otp_strobe_gen.sv
module otp_strobe_gen
    import otp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      start_prog,
    input  otp_lens_t start_lens,
    output logic      rd_stb,
    output logic      pg_stb,
    output logic      capture,
    output logic      done
);

    otp_phase_e        phase_q;
    logic [OTP_CW-1:0] cnt_q;
    logic              prog_q;
    otp_lens_t         lens_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            prog_q  <= 1'b0;
            lens_q  <= '0;
        end else if (start) begin
            phase_q <= PH_SETUP;
            cnt_q   <= start_lens.setup - OTP_CW'(1);
            prog_q  <= start_prog;
            lens_q  <= start_lens;
        end else if (phase_q != PH_IDLE) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - OTP_CW'(1);
            end else begin
                unique case (phase_q)
                    PH_SETUP: begin phase_q <= PH_PRE;  cnt_q <= lens_q.relax - OTP_CW'(1); end
                    PH_PRE:   begin phase_q <= PH_ACT;  cnt_q <= lens_q.pulse - OTP_CW'(1); end
                    PH_ACT:   begin phase_q <= PH_POST; cnt_q <= lens_q.relax - OTP_CW'(1); end
                    default:  phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign rd_stb  = (phase_q == PH_ACT) && !prog_q;
    assign pg_stb  = (phase_q == PH_ACT) &&  prog_q;
    assign capture = (phase_q == PH_ACT)  && (cnt_q == '0);
    assign done    = (phase_q == PH_POST) && (cnt_q == '0);

    // Independent run-length counter used only by the checks below.
    logic [OTP_CW-1:0] run_q;
    otp_phase_e        prev_phase_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q        <= '0;
            prev_phase_q <= PH_IDLE;
        end else begin
            prev_phase_q <= phase_q;
            run_q        <= (start || phase_q != prev_phase_q) ? OTP_CW'(1) : run_q + OTP_CW'(1);
        end
    end

    logic [OTP_CW-1:0] cur_run;
    assign cur_run = (phase_q != prev_phase_q) ? OTP_CW'(1) : run_q + OTP_CW'(1);

    p_pulse_width_r3: assert property (@(posedge clk) disable iff (rst)
        (capture && prev_phase_q != PH_IDLE) |-> (cur_run == lens_q.pulse));

    p_relax_tail_r3: assert property (@(posedge clk) disable iff (rst)
        (done && prev_phase_q != PH_IDLE) |-> (cur_run == lens_q.relax));

    p_single_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_stb, pg_stb}));

endmodule

// File: rtl/otp_shadow_bank.sv
module otp_shadow_bank #(
    parameter int NW = 8,
    parameter int DW = 32,
    parameter int IW = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic          or_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [NW-1:0] lock_set,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_word,
    output logic [NW-1:0] lock_q
);

    logic [DW-1:0] word_q [NW];

    for (genvar i = 0; i < NW; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[i] <= '0;
            end else if (wr_idx == IW'(i)) begin
                if (ld_en)      word_q[i] <= wr_data;
                else if (or_en) word_q[i] <= word_q[i] | wr_data;
            end
        end

        p_merge_keeps_ones_r4: assert property (@(posedge clk) disable iff (rst)
            (or_en && !ld_en && wr_idx == IW'(i)) |=> ((word_q[i] & $past(word_q[i])) == $past(word_q[i])));

        p_lock_sticky_r7: assert property (@(posedge clk) disable iff (rst)
            lock_q[i] |=> lock_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) lock_q <= '0;
        else     lock_q <= lock_q | lock_set;
    end

    assign rd_word = word_q[rd_idx];

endmodule

// File: rtl/otp_fuse_seq.sv
module otp_fuse_seq
    import otp_pkg::*;
#(
    parameter int          NW      = 8,
    parameter int          DW      = 32,
    parameter int          AW      = 6,
    parameter logic [31:0] VERSION = 32'h0001_0003
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    output logic [$clog2(NW)-1:0] fuse_addr,
    output logic                  fuse_rd_stb,
    output logic                  fuse_pg_stb,
    output logic [DW-1:0]         fuse_wdata,
    input  logic [DW-1:0]         fuse_rdata
);

    localparam int TBITS = $bits(otp_timing_t);
    localparam int IW    = $clog2(NW);

    // ---------------- bus decode ----------------
    logic       is_shadow;
    logic [2:0] reg_sel;
    logic       reg_we, cmd_we, clr_we;
    otp_op_e    cmd_op;
    logic [IW-1:0] cmd_idx;

    assign is_shadow = bus_addr[AW-1];
    assign reg_sel   = bus_addr[2:0];
    assign reg_we    = bus_we && !is_shadow;
    assign cmd_we    = reg_we && (reg_sel == REG_CMD);
    assign clr_we    = reg_we && (reg_sel == REG_ERRCLR);
    assign cmd_op    = otp_op_e'(bus_wdata[1:0]);
    assign cmd_idx   = bus_wdata[8 +: IW];

    // ---------------- state ----------------
    logic          busy_q, err_q;
    otp_op_e       op_q;
    logic [IW-1:0] idx_q;
    otp_timing_t   tim_reg, tim_q;
    logic [DW-1:0] pdata_q, pdata_lat;
    logic [NW-1:0] lock_q;

    logic accept, reject, restart, gen_start, gen_prog;
    logic capture, done;
    otp_lens_t gen_lens;

    assign reject  = cmd_we && (cmd_op != OP_NONE) &&
                     (busy_q || err_q || (cmd_op == OP_PROG && lock_q[cmd_idx]));
    assign accept  = cmd_we && (cmd_op != OP_NONE) && !reject;
    assign restart = busy_q && (op_q == OP_RELOAD) && done && (idx_q != IW'(NW - 1));

    assign gen_start = accept || restart;
    assign gen_prog  = accept ? (cmd_op == OP_PROG) : (op_q == OP_PROG);
    assign gen_lens  = make_lens(accept ? tim_reg : tim_q, gen_prog);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            err_q     <= 1'b0;
            op_q      <= OP_NONE;
            idx_q     <= '0;
            tim_reg   <= '0;
            tim_q     <= '0;
            pdata_q   <= '0;
            pdata_lat <= '0;
        end else begin
            if (reg_we && reg_sel == REG_PDATA)  pdata_q <= bus_wdata;
            if (reg_we && reg_sel == REG_TIMING) tim_reg <= otp_timing_t'(bus_wdata[TBITS-1:0]);

            if (accept) begin
                busy_q    <= 1'b1;
                op_q      <= cmd_op;
                idx_q     <= (cmd_op == OP_RELOAD) ? '0 : cmd_idx;
                tim_q     <= tim_reg;
                pdata_lat <= pdata_q;
            end else if (restart) begin
                idx_q <= idx_q + IW'(1);
            end else if (done) begin
                busy_q <= 1'b0;
            end

            if (reject)                     err_q <= 1'b1;
            else if (clr_we && bus_wdata[1]) err_q <= 1'b0;
        end
    end

    // ---------------- strobe timing ----------------
    otp_strobe_gen u_gen (
        .clk        (clk),
        .rst        (rst),
        .start      (gen_start),
        .start_prog (gen_prog),
        .start_lens (gen_lens),
        .rd_stb     (fuse_rd_stb),
        .pg_stb     (fuse_pg_stb),
        .capture    (capture),
        .done       (done)
    );

    // ---------------- shadow bank ----------------
    logic [DW-1:0] shadow_word;
    logic [NW-1:0] lock_set;
    logic          is_prog_op;

    assign is_prog_op = (op_q == OP_PROG);
    assign lock_set   = (reg_we && reg_sel == REG_LOCK) ? bus_wdata[NW-1:0] : '0;

    otp_shadow_bank #(.NW(NW), .DW(DW), .IW(IW)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (capture && !is_prog_op),
        .or_en    (capture &&  is_prog_op),
        .wr_idx   (idx_q),
        .wr_data  (is_prog_op ? pdata_lat : fuse_rdata),
        .lock_set (lock_set),
        .rd_idx   (bus_addr[IW-1:0]),
        .rd_word  (shadow_word),
        .lock_q   (lock_q)
    );

    assign fuse_addr  = idx_q;
    assign fuse_wdata = is_prog_op ? pdata_lat : '0;

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (is_shadow) begin
            bus_rdata = shadow_word;
        end else begin
            case (reg_sel)
                REG_CTRL:    bus_rdata[1:0]       = {err_q, busy_q};
                REG_PDATA:   bus_rdata            = pdata_q;
                REG_TIMING:  bus_rdata[TBITS-1:0] = tim_reg;
                REG_LOCK:    bus_rdata[NW-1:0]    = lock_q;
                REG_VERSION: bus_rdata            = DW'(VERSION);
                default:     bus_rdata            = '0;
            endcase
        end
    end

    // ---------------- checks ----------------
    p_strobe_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (fuse_rd_stb || fuse_pg_stb) |-> busy_q);

    p_busy_reject_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_op != OP_NONE && busy_q) |=> err_q);

    p_err_blocks_start_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && err_q && !busy_q) |=> !busy_q);

    p_err_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (err_q && !(clr_we && bus_wdata[1])) |=> err_q);

    p_locked_no_prog_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_op == OP_PROG && lock_q[cmd_idx]) |=> (err_q && !fuse_pg_stb));

endmodule

// File: tb/otp_fuse_seq_tb_top.sv
module otp_fuse_seq_tb_top;

    localparam int CLK_P = 10;
    localparam int NW    = 8;
    localparam int DW    = 32;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [2:0]    fuse_addr;
    logic          fuse_rd_stb, fuse_pg_stb;
    logic [DW-1:0] fuse_wdata, fuse_rdata;

    always #(CLK_P/2) clk = ~clk;

    otp_fuse_seq #(.NW(NW), .DW(DW), .AW(AW)) dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_addr(fuse_addr),
        .fuse_rd_stb(fuse_rd_stb), .fuse_pg_stb(fuse_pg_stb),
        .fuse_wdata(fuse_wdata), .fuse_rdata(fuse_rdata)
    );

    // ---------------- fuse array model ----------------
    logic [DW-1:0] fuse [NW];
    assign fuse_rdata = fuse[fuse_addr];
    always @(posedge clk) if (fuse_pg_stb) fuse[fuse_addr] <= fuse[fuse_addr] | fuse_wdata;

    // ---------------- strobe monitor ----------------
    int cyc = 0, rd_cnt = 0, pg_cnt = 0, rd_first = 0, pg_first = 0, log_n = 0;
    int addr_log [16];
    logic rd_prev = 0, pg_prev = 0;
    always @(negedge clk) begin
        cyc++;
        if (fuse_rd_stb) rd_cnt++;
        if (fuse_pg_stb) pg_cnt++;
        if (fuse_rd_stb && !rd_prev) begin
            rd_first = cyc;
            if (log_n < 16) addr_log[log_n] = int'(fuse_addr);
            log_n++;
        end
        if (fuse_pg_stb && !pg_prev) pg_first = cyc;
        rd_prev = fuse_rd_stb;
        pg_prev = fuse_pg_stb;
    end

    // ---------------- bookkeeping ----------------
    int n_chk = 0, n_fail = 0, t_issue = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        #1 t_issue = cyc;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0;
    endtask

    task automatic bread(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(input int t0, output int busy_cycles);
        forever begin
            @(negedge clk);
            bus_addr = '0;
            #1 if (!bus_rdata[0]) break;
        end
        busy_cycles = cyc - t0 - 1;
    endtask

    function automatic logic [31:0] tword(int sp, int sr, int rl, int wt);
        return {8'(sp), 8'(sr), 8'(rl), 8'(wt)};
    endfunction

    function automatic logic [31:0] cmd(int op, int idx);
        return {16'h0, 8'(idx), 6'h0, 2'(op)};
    endfunction

    localparam logic [AW-1:0] A_CTRL = 0, A_CMD = 1, A_PDATA = 2, A_TIM = 3,
                              A_LOCK = 4, A_CLR = 5, A_VER = 6, A_SH = 32;

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] d;
        bread(A_CTRL, d);   chk("R1 status after reset", d, 32'h0);
        bread(A_SH + 0, d); chk("R1 shadow0 after reset", d, 32'h0);
        bread(A_SH + 5, d); chk("R1 shadow5 after reset", d, 32'h0);
        chk("R1 no strobe after reset", {30'h0, fuse_rd_stb, fuse_pg_stb}, 32'h0);
    endtask

    task automatic t_read();
        logic [31:0] d; int r0, t0, b;
        bwrite(A_TIM, tword(20, 12, 2, 3));        // read pulse 13-6=7
        #1 r0 = rd_cnt;
        bwrite(A_CMD, cmd(1, 2)); t0 = t_issue;
        wait_idle(t0, b);
        chk("R2 read strobe start", 32'(rd_first - t0), 32'd8);
        chk("R3 read pulse width", 32'(rd_cnt - r0), 32'd7);
        chk("R5 read busy length", 32'(b), 32'd17);
        bread(A_SH + 2, d); chk("R2 shadow2 value", d, fuse[2]);
    endtask

    task automatic t_clamp();
        logic [31:0] d; int r0, t0, b;
        bwrite(A_TIM, tword(0, 2, 1, 0));          // 3-4 < 1 -> 1
        #1 r0 = rd_cnt;
        bwrite(A_CMD, cmd(1, 5)); t0 = t_issue;
        wait_idle(t0, b);
        chk("R3 clamped pulse width", 32'(rd_cnt - r0), 32'd1);
        chk("R3 clamped strobe start", 32'(rd_first - t0), 32'd4);
        chk("R3 clamped busy length", 32'(b), 32'd6);
        bread(A_SH + 5, d); chk("R2 shadow5 value", d, fuse[5]);
    endtask

    task automatic t_reload();
        logic [31:0] d; int r0, t0, b, l0;
        bwrite(A_TIM, tword(0, 4, 0, 1));          // 2+1+3+1 = 7 per word
        #1 begin r0 = rd_cnt; l0 = log_n; end
        bwrite(A_CMD, cmd(3, 6)); t0 = t_issue;
        wait_idle(t0, b);
        chk("R9 reload busy length", 32'(b), 32'd56);
        chk("R9 reload strobe cycles", 32'(rd_cnt - r0), 32'd24);
        for (int i = 0; i < NW; i++) begin
            chk("R9 reload order", 32'(addr_log[l0 + i]), 32'(i));
            bread(A_SH + AW'(i), d);
            chk("R9 reload shadow", d, fuse[i]);
        end
    endtask

    task automatic t_program();
        logic [31:0] d, old_sh, old_fu; int p0, t0, b;
        bread(A_SH + 3, old_sh);
        old_fu = fuse[3];
        bwrite(A_TIM, tword(20, 12, 2, 3));        // prog pulse 21-6=15
        bwrite(A_PDATA, 32'h00F0_300F);
        #1 p0 = pg_cnt;
        bwrite(A_CMD, cmd(2, 3)); t0 = t_issue;
        bwrite(A_PDATA, 32'hFFFF_FFFF);            // R11: latched data unchanged
        wait_idle(t0, b);
        chk("R4 program strobe start", 32'(pg_first - t0), 32'd7);
        chk("R4 program pulse width", 32'(pg_cnt - p0), 32'd15);
        chk("R5 program busy length", 32'(b), 32'd24);
        chk("R4 fuse programmed", fuse[3], old_fu | 32'h00F0_300F);
        bread(A_SH + 3, d); chk("R4 shadow OR merge", d, old_sh | 32'h00F0_300F);
    endtask

    task automatic t_reject_busy();
        logic [31:0] d, sh6; int r0, t0, b;
        bwrite(A_TIM, tword(0, 2, 1, 0));
        bread(A_SH + 6, sh6);
        fuse[6] = fuse[6] ^ 32'h0000_FF00;
        #1 r0 = rd_cnt;
        bwrite(A_CMD, cmd(1, 1)); t0 = t_issue;
        bwrite(A_CMD, cmd(1, 6));
        wait_idle(t0, b);
        chk("R6 busy reject one pulse", 32'(rd_cnt - r0), 32'd1);
        bread(A_CTRL, d); chk("R6 error after busy reject", d, 32'h2);
        bread(A_SH + 6, d); chk("R6 shadow6 untouched", d, sh6);
        #1 r0 = rd_cnt;
        bwrite(A_CMD, cmd(1, 6));
        repeat (10) @(negedge clk);
        chk("R6 error blocks strobe", 32'(rd_cnt - r0), 32'd0);
        bread(A_CTRL, d); chk("R6 error stays, not busy", d, 32'h2);
        bread(A_SH + 6, d); chk("R6 shadow6 still untouched", d, sh6);
    endtask

    task automatic t_errclr();
        logic [31:0] d;
        bwrite(A_CLR, 32'h0);
        bread(A_CTRL, d); chk("R8 zero write keeps error", d, 32'h2);
        bwrite(A_CLR, 32'h2);
        bread(A_CTRL, d); chk("R8 one clears error", d, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] d, f4; int p0;
        bwrite(A_LOCK, 32'h10);
        bwrite(A_LOCK, 32'h00);
        bread(A_LOCK, d); chk("R7 lock sticky", d, 32'h10);
        f4 = fuse[4];
        bwrite(A_PDATA, 32'h0000_0001);
        #1 p0 = pg_cnt;
        bwrite(A_CMD, cmd(2, 4));
        repeat (30) @(negedge clk);
        chk("R7 locked no strobe", 32'(pg_cnt - p0), 32'd0);
        chk("R7 locked fuse unchanged", fuse[4], f4);
        bread(A_CTRL, d); chk("R7 locked sets error", d, 32'h2);
        bwrite(A_CLR, 32'h2);
    endtask

    task automatic t_timing_sample();
        logic [31:0] d; int r0, t0, b;
        bwrite(A_TIM, tword(0, 8, 1, 4));          // 9-4 = 5
        #1 r0 = rd_cnt;
        bwrite(A_CMD, cmd(1, 0)); t0 = t_issue;
        bwrite(A_TIM, tword(0, 0, 0, 0));
        wait_idle(t0, b);
        chk("R11 sampled pulse width", 32'(rd_cnt - r0), 32'd5);
        chk("R11 sampled busy length", 32'(b), 32'd14);
        bread(A_TIM, d); chk("R11 new timing stored", d, 32'h0);
    endtask

    task automatic t_version();
        logic [31:0] d;
        bread(A_VER, d); chk("R10 version value", d, 32'h0001_0003);
        bwrite(A_VER, 32'hDEAD_BEEF);
        bread(A_VER, d); chk("R10 version after write", d, 32'h0001_0003);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) fuse[i] = {8'hC3, 8'(i), 8'(i * 17), 8'h5A};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read();
        t_clamp();
        t_reload();
        t_program();
        t_reject_busy();
        t_errclr();
        t_lock();
        t_timing_sample();
        t_version();
        summary();
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL R5 watchdog actual=busy expected=idle");
        summary();
        $finish;
    end

endmodule